// File: doc/BRIEF.md
# Pipelined Transposed-Form FIR Filter

This block is a fully parallel finite impulse response filter that takes one signed sample on every clock and delivers one filtered result on every clock, with no stall and no back-pressure. The tap weights are fixed at elaboration through a parameter list. Internally the structure is the transposed form: every tap owns a multiplier whose product is added into a running partial sum, and a delay register sits between neighbouring adders. The oldest tap sits at the far end of the chain and the newest tap is nearest the output.

The multiplier sits on the longest path, so each one is cut in two. The sample is split into a low half, treated as unsigned, and a signed high half. Both partial products are registered, then shifted and added in the next cycle. The delay before the cut and the delay after it are roughly equal, which brings the clock period close to half of one multiply plus one add. Optional input and output registers add one cycle each. A valid strobe travels beside the data with the same fixed delay. A cycle without a valid sample feeds a zero into the delay line.

The result port is wide enough for the full-precision sum: data width plus coefficient width plus the ceiling of log2 of the tap count.

Top module: `fir_transposed_pipe`

## Requirements
- R1: While reset is high, and on the first clock after it is released, out_valid is 0 and out_data is 0.
- R2: For a stream of samples x[n], out_data equals the exact sum over k of COEFS[k]*x[n-k], with COEFS[0] applied to the newest sample.
- R3: out_valid equals in_valid delayed by IN_REG + OUT_REG + 2 clocks. This is 4 clocks with the default parameters.
- R4: A cycle with in_valid at 0 enters the delay line as a zero sample, whatever value in_data carries in that cycle.
- R5: A single sample of value 1 after reset, followed by zeros, produces COEFS[0], COEFS[1], and so on through the last coefficient on consecutive valid outputs, then zero.
- R6: Full-scale inputs (most negative and most positive codes, with signs matched to the coefficients) produce the exact sum with no wrap. out_data never leaves plus or minus (sum of |COEFS|) * 2^(DATA_W-1).
- R7: Samples presented on back-to-back clocks are all accepted, and each yields its own result one clock after the previous one.
- R8: Reset given in the middle of a stream clears every tap register, so no older sample contributes to any result after reset.
- R9: Each split multiplier returns the exact product for every sample pattern, including a low half of all ones, a negative high half, and the codes -1, 1 and the most negative value.
- R10: After TAPS + LAT cycles in a row with no nonzero valid sample, out_data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_data as a sample this cycle |
| in_data | input | DATA_W (12) | Signed input sample |
| out_valid | output | 1 | Marks out_data as the result for a valid sample |
| out_data | output | ACC_W (25) | Signed full-precision filter result |

## Verification
The main table mixes small values, full-scale codes of both signs, patterns that set every bit of the low half, and gaps that carry nonzero data with valid low. Coefficient order, partial-product recombination and zero insertion therefore each show up as a distinct wrong sum. Impulses of +1 and -1 bring out each tap weight by itself and in order, which separates a reversed adder chain from a correct one. Sign-matched full-scale runs reach the largest possible magnitude, so a narrowed accumulator would wrap. A reset in mid-stream, followed by zeros, shows whether any tap register kept old history.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // Full-precision result width for a sum of taps products.
  function automatic int acc_width(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction

  function automatic longint mag(input int v);
    return (v < 0) ? -longint'(v) : longint'(v);
  endfunction

endpackage

// File: rtl/fir_valid_pipe.sv
module fir_valid_pipe #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[DEPTH-2:0], din};
  end

  assign dout = sh[DEPTH-1];

endmodule

// File: rtl/fir_split_mul.sv
module fir_split_mul #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 10,
  parameter int COEF   = 1,
  localparam int P_W   = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] x_in,
  output logic signed [P_W-1:0]    prod
);

  localparam int LO_W = DATA_W / 2;
  localparam int HI_W = DATA_W - LO_W;
  localparam int PL_W = COEF_W + LO_W + 1;
  localparam int PH_W = COEF_W + HI_W;
  localparam logic signed [COEF_W-1:0] C = COEF_W'(COEF);

  logic signed [PL_W-1:0] c_lo, x_lo, pp_lo_d, pp_lo;
  logic signed [PH_W-1:0] c_hi, x_hi, pp_hi_d, pp_hi;

  // First half: two narrow partial products.
  always_comb begin
    c_lo    = PL_W'(C);
    x_lo    = PL_W'({1'b0, x_in[LO_W-1:0]});
    c_hi    = PH_W'(C);
    x_hi    = PH_W'($signed(x_in[DATA_W-1:LO_W]));
    pp_lo_d = c_lo * x_lo;
    pp_hi_d = c_hi * x_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_lo <= '0;
      pp_hi <= '0;
    end else begin
      pp_lo <= pp_lo_d;
      pp_hi <= pp_hi_d;
    end
  end

  // Second half: recombine the registered halves.
  assign prod = (P_W'(pp_hi) <<< LO_W) + P_W'(pp_lo);

  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  // R9
  split_prod_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> (longint'(prod) == longint'($past(x_in)) * longint'(C)));

endmodule

// File: rtl/fir_tap_chain.sv
module fir_tap_chain #(
  parameter int DATA_W = 12,
  parameter int P_W    = 22,
  parameter int ACC_W  = 25,
  parameter int TAPS   = 5,
  parameter int COEFS [TAPS] = '{-512, 37, 100, -1, 511}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [P_W-1:0]   prod [TAPS],
  output logic signed [ACC_W-1:0] acc
);

  logic signed [ACC_W-1:0] z [TAPS];

  // Reversed chain: the oldest tap enters at the far end.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) z[k] <= '0;
    end else begin
      for (int k = 0; k < TAPS - 1; k++) z[k] <= ACC_W'(prod[k]) + z[k+1];
      z[TAPS-1] <= ACC_W'(prod[TAPS-1]);
    end
  end

  assign acc = z[0];

  function automatic longint abs_sum();
    longint s = 0;
    for (int k = 0; k < TAPS; k++) s += fir_pkg::mag(COEFS[k]);
    return s;
  endfunction

  localparam longint BOUND = abs_sum() * (longint'(1) << (DATA_W - 1));

  // R6
  acc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (longint'(acc) <= BOUND) && (longint'(acc) >= -BOUND));

endmodule

// File: rtl/fir_transposed_pipe.sv
module fir_transposed_pipe #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 10,
  parameter int TAPS   = 5,
  parameter int COEFS [TAPS] = '{-512, 37, 100, -1, 511},
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  localparam int ACC_W = fir_pkg::acc_width(DATA_W, COEF_W, TAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [ACC_W-1:0]  out_data
);

  localparam int P_W   = DATA_W + COEF_W;
  localparam int LAT   = 2 + int'(IN_REG) + int'(OUT_REG);
  localparam int FLUSH = TAPS + LAT;

  logic signed [DATA_W-1:0] x_gated, x_s;
  logic signed [P_W-1:0]    prod [TAPS];
  logic signed [ACC_W-1:0]  acc;

  assign x_gated = in_valid ? in_data : '0;

  generate
    if (IN_REG) begin : g_in_reg
      always_ff @(posedge clk) begin
        if (rst) x_s <= '0;
        else     x_s <= x_gated;
      end
    end else begin : g_in_wire
      assign x_s = x_gated;
    end
  endgenerate

  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      fir_split_mul #(
        .DATA_W(DATA_W),
        .COEF_W(COEF_W),
        .COEF  (COEFS[k])
      ) u_mul (
        .clk (clk),
        .rst (rst),
        .x_in(x_s),
        .prod(prod[k])
      );
    end
  endgenerate

  fir_tap_chain #(
    .DATA_W(DATA_W),
    .P_W   (P_W),
    .ACC_W (ACC_W),
    .TAPS  (TAPS),
    .COEFS (COEFS)
  ) u_chain (
    .clk (clk),
    .rst (rst),
    .prod(prod),
    .acc (acc)
  );

  generate
    if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
        if (rst) out_data <= '0;
        else     out_data <= acc;
      end
    end else begin : g_out_wire
      assign out_data = acc;
    end
  endgenerate

  fir_valid_pipe #(.DEPTH(LAT)) u_vpipe (
    .clk (clk),
    .rst (rst),
    .din (in_valid),
    .dout(out_valid)
  );

  // Cycles since reset, saturating at LAT.
  logic [$clog2(LAT+1)-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                         since_rst <= '0;
    else if (int'(since_rst) < LAT)  since_rst <= since_rst + 1'b1;
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(since_rst) == LAT) |-> (out_valid == $past(in_valid, LAT)));

  // Consecutive cycles with no nonzero valid sample, saturating at FLUSH.
  logic [$clog2(FLUSH+1)-1:0] zrun;
  always_ff @(posedge clk) begin
    if (rst)                         zrun <= '0;
    else if (in_valid && in_data != '0) zrun <= '0;
    else if (int'(zrun) < FLUSH)     zrun <= zrun + 1'b1;
  end

  // R10
  zero_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(zrun) == FLUSH) |-> (out_data == '0));

endmodule

// File: tb/tb_fir_transposed_pipe.sv
`timescale 1ns/1ps
module tb_fir_transposed_pipe;

  localparam int DW    = 12;
  localparam int ACC_W = 25;
  localparam int TAPS  = 5;
  localparam int LAT   = 4;
  localparam int COEF [TAPS] = '{-512, 37, 100, -1, 511};
  localparam int NVEC  = 20;
  // Bit 12 = valid, bits 11:0 = sample.
  localparam logic [DW:0] VEC [NVEC] = '{
    13'h1001, 13'h17FF, 13'h1800, 13'h0123, 13'h1FFF,
    13'h103F, 13'h1040, 13'h1FC0, 13'h07FF, 13'h0000,
    13'h1555, 13'h1AAA, 13'h1100, 13'h1F00, 13'h1001,
    13'h1000, 13'h17C1, 13'h183F, 13'h0800, 13'h12B6};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic out_valid;
  logic signed [ACC_W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  longint hist [TAPS];
  bit     pv   [LAT];
  longint pd   [LAT];

  always #2.5 clk = ~clk;

  fir_transposed_pipe dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    for (int k = 0; k < LAT; k++) begin pv[k] = 1'b0; pd[k] = 0; end
  endtask

  // Called just after a falling edge: check, drive, advance one clock.
  task automatic step(input bit v, input logic [DW-1:0] d, input string req);
    longint y;
    check(req, longint'(out_valid), longint'(pv[LAT-1]));
    check(req, longint'(out_data), pd[LAT-1]);
    in_valid = v;
    in_data  = d;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v ? longint'($signed(d)) : 0;
    y = 0;
    for (int k = 0; k < TAPS; k++) y += longint'(COEF[k]) * hist[k];
    for (int k = LAT - 1; k > 0; k--) begin pv[k] = pv[k-1]; pd[k] = pd[k-1]; end
    pv[0] = v;
    pd[0] = y;
    @(negedge clk);
  endtask

  task automatic do_reset(input int cycles);
    rst = 1'b1;
    in_valid = 1'b0;
    in_data = 12'h5A5;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check("R1", longint'(out_valid), 0);
      check("R1", longint'(out_data), 0);
    end
    rst = 1'b0;
    model_clear();
  endtask

  task automatic zeros(input int n, input bit v, input string req);
    for (int i = 0; i < n; i++) step(v, 12'h000, req);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset(3);
    // R1: first clock after release still idle
    step(1'b0, 12'h000, "R1");

    // R2 R4 R7 R9: table walk, back-to-back with gaps
    for (int i = 0; i < NVEC; i++) step(VEC[i][DW], VEC[i][DW-1:0], "R2");
    zeros(TAPS + LAT, 1'b1, "R7");

    // R5: unit impulse yields the coefficient list in order
    do_reset(2);
    step(1'b1, 12'h001, "R5");
    zeros(TAPS + LAT, 1'b1, "R5");

    // R9: impulse of -1 and of the most negative code
    step(1'b1, 12'hFFF, "R9");
    zeros(TAPS, 1'b1, "R9");
    step(1'b1, 12'h800, "R9");
    step(1'b1, 12'h03F, "R9");
    zeros(TAPS + LAT, 1'b1, "R9");

    // R4: invalid cycles carry nonzero data that must be ignored
    step(1'b1, 12'h010, "R4");
    step(1'b0, 12'h7FF, "R4");
    step(1'b0, 12'h800, "R4");
    step(1'b1, 12'hFF0, "R4");
    zeros(TAPS + LAT, 1'b0, "R4");

    // R3: isolated valid pulses
    step(1'b1, 12'h002, "R3");
    step(1'b0, 12'h000, "R3");
    step(1'b1, 12'h003, "R3");
    zeros(LAT + 1, 1'b0, "R3");

    // R6: sign-matched full scale, both polarities
    step(1'b1, 12'h7FF, "R6");
    step(1'b1, 12'h800, "R6");
    step(1'b1, 12'h7FF, "R6");
    step(1'b1, 12'h7FF, "R6");
    step(1'b1, 12'h800, "R6");
    step(1'b1, 12'h800, "R6");
    step(1'b1, 12'h7FF, "R6");
    step(1'b1, 12'h800, "R6");
    step(1'b1, 12'h800, "R6");
    step(1'b1, 12'h7FF, "R6");
    for (int i = 0; i < TAPS; i++) step(1'b1, 12'h800, "R6");
    zeros(TAPS + LAT, 1'b1, "R10");

    // R8: reset in mid-stream wipes history
    step(1'b1, 12'h321, "R8");
    step(1'b1, 12'h9AB, "R8");
    step(1'b1, 12'h7FF, "R8");
    do_reset(2);
    zeros(TAPS + LAT, 1'b1, "R8");
    step(1'b1, 12'h004, "R8");
    zeros(TAPS + LAT, 1'b1, "R8");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule